// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine stores incoming frames into memory buffers that software describes with a linked list of four-word descriptors. It has a single word-addressed memory port, 32 bits wide, with a read latency of one cycle. All addresses, including buffer and descriptor pointers, count in words. Descriptors start on 4-word boundaries.

For each frame, the engine reads the descriptor at its current pointer. If software still owns the descriptor, the engine waits in a suspended state until software writes a poll demand. If the engine owns it, the engine packs the frame bytes into the buffer, little-endian. It then closes the descriptor with a single status write that also hands the descriptor back to software. After that it moves to the next descriptor: the chained pointer, the list base, or the next four-word slot.

A frame arrives as a byte stream with a valid/ready handshake. A 3-bit process code shows what the engine is doing at each moment. A sticky receive-complete flag tells software that a descriptor has been closed.

Top module: `rxd_ring_dma`

## Requirements
- R1: After reset the process code is 0 (stopped), `irq_rx` is 0, `mem_req` is 0 and `frm_ready` is 0.
- R2: When `rx_start` rises from stopped, the engine reads word 0 of the descriptor at `desc_base`. If that word has bit 31 (ownership) clear, the engine enters the suspended state (code 4) and does not accept frame bytes.
- R3: In the suspended state, a `poll_demand` pulse makes the engine read the same descriptor again. A poll pulse in any other state has no effect.
- R4: Frame bytes are written little-endian (first byte in bits 7:0) into consecutive words starting at the buffer address in descriptor word 2. The unused upper bytes of a partly filled final word are written as zero.
- R5: The writeback to word 0 comes after every data write of the frame. It has bit 31 clear, the stored byte count in bits 29:16, bit 9 (first) and bit 8 (last) set, and bit 15 (error summary) set when any byte arrived with `frm_err`.
- R6: Bytes beyond the buffer size in word 1 bits 11:0 are dropped and not written. The writeback then reports the buffer size as the length and sets bit 15.
- R7: After a writeback, the next descriptor is chosen in this order. If word 1 bit 15 (end of ring) is set, it is `desc_base`. Otherwise, if word 1 bit 14 (chained) is set, it is the address in word 3. Otherwise it is the current descriptor address plus 4.
- R8: `irq_rx` is set in the cycle after each writeback and stays set until an `irq_clr` pulse. A set in the same cycle as a clear wins.
- R9: The process code is one of the following: 0 stopped, 1 fetching a descriptor, 3 waiting for a frame, 4 suspended, 5 closing the descriptor, 7 writing frame data.
- R10: With `rx_start` low, the engine goes from waiting or suspended to stopped. A later restart fetches from the current `desc_base`.
- R11: `frm_ready` is high only while the process code is 7.
- R12: The memory port is idle while the engine is stopped, waiting or suspended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Run enable for the receive process |
| desc_base | input | AW | Word address of the descriptor list base |
| poll_demand | input | 1 | One-cycle pulse that restarts the descriptor fetch from suspended |
| frm_valid | input | 1 | Frame byte valid |
| frm_data | input | 8 | Frame byte |
| frm_last | input | 1 | Marks the final byte of a frame |
| frm_err | input | 1 | Marks the byte as received with an error |
| frm_ready | output | 1 | Engine accepts the frame byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| proc_state | output | 3 | Process code |
| irq_rx | output | 1 | Sticky receive-complete flag |
| irq_clr | input | 1 | Write-1 pulse that clears `irq_rx` |

## Verification
The bound checker watches several rules on every cycle:
- the process code stays within its legal set;
- every close cycle is a single write that clears ownership and sets the first and last bits;
- the complete flag rises only after a close;
- byte acceptance happens only in the writing state;
- a suspended engine stays suspended without a poll;
- the engine stops when the run enable falls;
- the memory port stays quiet in the idle states.

Other behaviour shows only in the bench scenarios, which read the memory afterwards and the descriptor addresses the engine fetched:
- little-endian packing with zero fill;
- the length and error fields;
- truncation leaving the following words untouched;
- the chained, end-of-ring and contiguous choice of the next descriptor;
- reloading the base on restart.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [2:0] {
    PS_STOP  = 3'd0,
    PS_FETCH = 3'd1,
    PS_WAIT  = 3'd3,
    PS_SUSP  = 3'd4,
    PS_CLOSE = 3'd5,
    PS_WRITE = 3'd7
  } proc_e;

  localparam int WORD_W    = 32;
  localparam int LEN_W     = 14;
  localparam int SIZE_W    = 12;
  localparam int IDX_W     = LEN_W - 2;
  localparam int OWN_BIT   = 31;
  localparam int ES_BIT    = 15;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  localparam int LEN_LSB   = 16;
  localparam int CHAIN_BIT = 14;
  localparam int EOR_BIT   = 15;
  localparam int DESC_WDS  = 4;

endpackage

// File: rtl/rxd_packer.sv
module rxd_packer
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_ok,
  input  logic [7:0]        byte_in,
  input  logic              byte_last,
  input  logic              byte_err,
  input  logic [SIZE_W-1:0] buf_size,
  input  logic              take,
  output logic              wr_pend,
  output logic [WORD_W-1:0] wr_word,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [LEN_W-1:0]  stored_len,
  output logic              bad,
  output logic              last_seen
);

  localparam int PAD_W = LEN_W - SIZE_W;

  logic [WORD_W-1:0] acc_q, acc_n, pdata_q, pdata_n;
  logic [1:0]        lane_q, lane_n;
  logic              has_q, has_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  widx_q, widx_n;
  logic              pend_q, pend_n;
  logic              trunc_q, trunc_n;
  logic              err_q, err_n;
  logic              last_q, last_n;
  logic              en;
  logic [WORD_W-1:0] acc_v;
  logic              room;

  assign en   = clr | byte_ok | take;
  assign room = cnt_q < {{PAD_W{1'b0}}, buf_size};

  always_comb begin
    acc_n   = acc_q;
    pdata_n = pdata_q;
    lane_n  = lane_q;
    has_n   = has_q;
    cnt_n   = cnt_q;
    widx_n  = widx_q;
    pend_n  = pend_q;
    trunc_n = trunc_q;
    err_n   = err_q;
    last_n  = last_q;
    acc_v   = acc_q;
    acc_v[{lane_q, 3'b000} +: 8] = byte_in;
    if (clr) begin
      acc_n   = '0;
      pdata_n = '0;
      lane_n  = '0;
      has_n   = 1'b0;
      cnt_n   = '0;
      widx_n  = '0;
      pend_n  = 1'b0;
      trunc_n = 1'b0;
      err_n   = 1'b0;
      last_n  = 1'b0;
    end else begin
      if (take) begin
        pend_n = 1'b0;
        widx_n = widx_q + 1'b1;
      end
      if (byte_ok) begin
        err_n  = err_q | byte_err;
        last_n = last_q | byte_last;
        if (room) begin
          cnt_n = cnt_q + 1'b1;
          if (lane_q == 2'd3 || byte_last) begin
            pend_n  = 1'b1;
            pdata_n = acc_v;
            acc_n   = '0;
            lane_n  = '0;
            has_n   = 1'b0;
          end else begin
            acc_n  = acc_v;
            lane_n = lane_q + 1'b1;
            has_n  = 1'b1;
          end
        end else begin
          trunc_n = 1'b1;
          if (byte_last && has_q) begin
            pend_n  = 1'b1;
            pdata_n = acc_q;
            acc_n   = '0;
            lane_n  = '0;
            has_n   = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pdata_q <= '0;
      lane_q  <= '0;
      has_q   <= 1'b0;
      cnt_q   <= '0;
      widx_q  <= '0;
      pend_q  <= 1'b0;
      trunc_q <= 1'b0;
      err_q   <= 1'b0;
      last_q  <= 1'b0;
    end else if (en) begin
      acc_q   <= acc_n;
      pdata_q <= pdata_n;
      lane_q  <= lane_n;
      has_q   <= has_n;
      cnt_q   <= cnt_n;
      widx_q  <= widx_n;
      pend_q  <= pend_n;
      trunc_q <= trunc_n;
      err_q   <= err_n;
      last_q  <= last_n;
    end
  end

  assign wr_pend    = pend_q;
  assign wr_word    = pdata_q;
  assign wr_idx     = widx_q;
  assign stored_len = cnt_q;
  assign bad        = trunc_q | err_q;
  assign last_seen  = last_q;

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [AW-1:0]     base,
  input  logic              poll,
  input  logic              frm_valid,
  output logic              frm_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              pk_clr,
  output logic              pk_take,
  input  logic              pk_pend,
  input  logic [WORD_W-1:0] pk_word,
  input  logic [IDX_W-1:0]  pk_idx,
  input  logic [LEN_W-1:0]  pk_len,
  input  logic              pk_bad,
  input  logic              pk_last,
  output logic [SIZE_W-1:0] buf_size,
  output logic              close_pulse,
  output proc_e             state
);

  proc_e             st_q, st_n;
  logic [1:0]        fidx_q, fidx_n;
  logic              fph_q, fph_n;
  logic [AW-1:0]     cur_q, cur_n;
  logic [WORD_W-1:0] ctl_q, ctl_n;
  logic [AW-1:0]     buf_q, buf_n;
  logic [AW-1:0]     nxt_q, nxt_n;
  logic [AW-1:0]     next_desc;
  logic [WORD_W-1:0] close_word;

  always_comb begin
    if (ctl_q[EOR_BIT])        next_desc = base;
    else if (ctl_q[CHAIN_BIT]) next_desc = nxt_q;
    else                       next_desc = cur_q + AW'(DESC_WDS);
  end

  always_comb begin
    close_word                          = '0;
    close_word[LEN_LSB +: LEN_W]        = pk_len;
    close_word[ES_BIT]                  = pk_bad;
    close_word[FIRST_BIT]               = 1'b1;
    close_word[LAST_BIT]                = 1'b1;
  end

  always_comb begin
    st_n        = st_q;
    fidx_n      = fidx_q;
    fph_n       = fph_q;
    cur_n       = cur_q;
    ctl_n       = ctl_q;
    buf_n       = buf_q;
    nxt_n       = nxt_q;
    frm_ready   = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = cur_q;
    mem_wdata   = '0;
    pk_clr      = 1'b0;
    pk_take     = 1'b0;
    close_pulse = 1'b0;
    unique case (st_q)
      PS_STOP: begin
        if (run) begin
          cur_n  = base;
          fidx_n = '0;
          fph_n  = 1'b0;
          st_n   = PS_FETCH;
        end
      end
      PS_FETCH: begin
        if (!fph_q) begin
          mem_req  = 1'b1;
          mem_addr = cur_q + AW'(fidx_q);
          fph_n    = 1'b1;
        end else begin
          fph_n  = 1'b0;
          fidx_n = fidx_q + 1'b1;
          unique case (fidx_q)
            2'd0: begin
              if (!mem_rdata[OWN_BIT]) begin
                fidx_n = '0;
                st_n   = PS_SUSP;
              end
            end
            2'd1: ctl_n = mem_rdata;
            2'd2: buf_n = mem_rdata[AW-1:0];
            default: begin
              nxt_n  = mem_rdata[AW-1:0];
              fidx_n = '0;
              st_n   = PS_WAIT;
            end
          endcase
        end
      end
      PS_WAIT: begin
        pk_clr = 1'b1;
        if (!run)           st_n = PS_STOP;
        else if (frm_valid) st_n = PS_WRITE;
      end
      PS_WRITE: begin
        frm_ready = !pk_pend && !pk_last;
        if (pk_pend) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = buf_q + AW'(pk_idx);
          mem_wdata = pk_word;
          pk_take   = 1'b1;
        end else if (pk_last) begin
          st_n = PS_CLOSE;
        end
      end
      PS_CLOSE: begin
        mem_req     = 1'b1;
        mem_we      = 1'b1;
        mem_addr    = cur_q;
        mem_wdata   = close_word;
        close_pulse = 1'b1;
        cur_n       = next_desc;
        fidx_n      = '0;
        fph_n       = 1'b0;
        st_n        = run ? PS_FETCH : PS_STOP;
      end
      PS_SUSP: begin
        if (!run)      st_n = PS_STOP;
        else if (poll) st_n = PS_FETCH;
      end
      default: st_n = PS_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_STOP;
      fidx_q <= '0;
      fph_q  <= 1'b0;
      cur_q  <= '0;
      ctl_q  <= '0;
      buf_q  <= '0;
      nxt_q  <= '0;
    end else begin
      st_q   <= st_n;
      fidx_q <= fidx_n;
      fph_q  <= fph_n;
      cur_q  <= cur_n;
      ctl_q  <= ctl_n;
      buf_q  <= buf_n;
      nxt_q  <= nxt_n;
    end
  end

  assign buf_size = ctl_q[SIZE_W-1:0];
  assign state    = st_q;

endmodule

// File: rtl/rxd_status.sv
module rxd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);

  logic flag_q, flag_n, en;

  assign en = set_evt | clr_evt;

  always_comb begin
    flag_n = flag_q;
    if (set_evt)      flag_n = 1'b1;
    else if (clr_evt) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag_q <= 1'b0;
    else if (en) flag_q <= flag_n;
  end

  assign flag = flag_q;

endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma
  import rxd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic [AW-1:0] desc_base,
  input  logic          poll_demand,
  input  logic          frm_valid,
  input  logic [7:0]    frm_data,
  input  logic          frm_last,
  input  logic          frm_err,
  output logic          frm_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [2:0]    proc_state,
  output logic          irq_rx,
  input  logic          irq_clr
);

  logic              pk_clr, pk_take, pk_pend, pk_bad, pk_last, close_pulse;
  logic [WORD_W-1:0] pk_word;
  logic [IDX_W-1:0]  pk_idx;
  logic [LEN_W-1:0]  pk_len;
  logic [SIZE_W-1:0] buf_size;
  logic              byte_ok;
  proc_e             state;

  assign byte_ok = frm_valid & frm_ready;

  rxd_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .run(rx_start), .base(desc_base), .poll(poll_demand),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pk_clr(pk_clr), .pk_take(pk_take), .pk_pend(pk_pend), .pk_word(pk_word),
    .pk_idx(pk_idx), .pk_len(pk_len), .pk_bad(pk_bad), .pk_last(pk_last),
    .buf_size(buf_size), .close_pulse(close_pulse), .state(state)
  );

  rxd_packer packer_i (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .byte_ok(byte_ok), .byte_in(frm_data),
    .byte_last(frm_last), .byte_err(frm_err), .buf_size(buf_size), .take(pk_take),
    .wr_pend(pk_pend), .wr_word(pk_word), .wr_idx(pk_idx), .stored_len(pk_len),
    .bad(pk_bad), .last_seen(pk_last)
  );

  rxd_status status_i (
    .clk(clk), .rst_n(rst_n), .set_evt(close_pulse), .clr_evt(irq_clr), .flag(irq_rx)
  );

  assign proc_state = state;

endmodule

// File: rtl/rxd_ring_dma_chk.sv
module rxd_ring_dma_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_start,
  input logic          poll_demand,
  input logic          frm_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic [2:0]    proc_state,
  input logic          irq_rx
);

  a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    proc_state inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd7});

  a_r5_close_write: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd5) |-> (mem_req && mem_we && !mem_wdata[31] && mem_wdata[9] && mem_wdata[8]));

  a_r8_irq_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> ($past(proc_state) == 3'd5));

  a_r11_ready_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> (proc_state == 3'd7));

  a_r3_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd4 && rx_start && !poll_demand) |=> (proc_state == 3'd4));

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_start && (proc_state == 3'd3 || proc_state == 3'd4)) |=> (proc_state == 3'd0));

  a_r12_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd0 || proc_state == 3'd3 || proc_state == 3'd4) |-> !mem_req);

endmodule

bind rxd_ring_dma rxd_ring_dma_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .poll_demand(poll_demand),
  .frm_ready(frm_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .proc_state(proc_state), .irq_rx(irq_rx)
);

// File: tb/rxd_ring_dma_tb_top.sv
`timescale 1ns/1ps
module rxd_ring_dma_tb_top;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_start = 1'b0;
  logic [AW-1:0] desc_base = '0;
  logic          poll_demand = 1'b0;
  logic          frm_valid = 1'b0;
  logic [7:0]    frm_data = '0;
  logic          frm_last = 1'b0;
  logic          frm_err = 1'b0;
  logic          frm_ready;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;
  logic [2:0]    proc_state;
  logic          irq_rx;
  logic          irq_clr = 1'b0;

  logic [31:0]   mem [256];
  logic [AW-1:0] last_desc;
  int            n_chk = 0;
  int            n_err = 0;
  int            cyc = 0;
  logic          saw_write;

  always #2.5 clk = ~clk;

  rxd_ring_dma #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .desc_base(desc_base),
    .poll_demand(poll_demand), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_last(frm_last), .frm_err(frm_err), .frm_ready(frm_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .proc_state(proc_state), .irq_rx(irq_rx), .irq_clr(irq_clr)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_addr[1:0] == 2'b00) last_desc <= mem_addr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic set_desc(input int a, input bit own, input int size, input bit chain,
                          input bit eor, input int bufa, input int nxt);
    mem[a]     = {own, 31'd0};
    mem[a + 1] = {16'd0, eor, chain, 2'b00, size[11:0]};
    mem[a + 2] = 32'(bufa);
    mem[a + 3] = 32'(nxt);
  endtask

  task automatic wait_state(input logic [2:0] code);
    for (int i = 0; i < 400; i++) begin
      if (proc_state == code) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_poll();
    poll_demand = 1'b1;
    @(negedge clk);
    poll_demand = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] first, input int err_at);
    saw_write = 1'b0;
    for (int i = 0; i < n; i++) begin
      frm_valid = 1'b1;
      frm_data  = first + 8'(i);
      frm_last  = (i == n - 1);
      frm_err   = (i == err_at);
      for (int k = 0; k < 100; k++) begin
        if (frm_ready) break;
        @(negedge clk);
      end
      if (proc_state == 3'd7) saw_write = 1'b1;
      @(negedge clk);
    end
    frm_valid = 1'b0;
    frm_last  = 1'b0;
    frm_err   = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1 state", 32'(proc_state), 32'd0);
    chk_eq("R1 irq", 32'(irq_rx), 32'd0);
    chk_eq("R1 mem_req", 32'(mem_req), 32'd0);
    chk_eq("R1 ready", 32'(frm_ready), 32'd0);
  endtask

  task automatic t_suspend_and_poll();
    set_desc(16, 1'b0, 64, 1'b1, 1'b0, 64, 32);
    desc_base = 16'h0010;
    rx_start  = 1'b1;
    wait_state(3'd4);
    frm_valid = 1'b1;
    @(negedge clk);
    chk_eq("R2 suspended", 32'(proc_state), 32'd4);
    chk_eq("R2 fetched base", 32'(last_desc), 32'h10);
    chk_eq("R11 no ready when suspended", 32'(frm_ready), 32'd0);
    frm_valid = 1'b0;
    mem[16] = 32'h8000_0000;
    set_desc(32, 1'b0, 5, 1'b0, 1'b0, 80, 0);
    pulse_poll();
    wait_state(3'd3);
    chk_eq("R3 poll resumes to wait (R9 code 3)", 32'(proc_state), 32'd3);
    pulse_poll();
    @(negedge clk);
    chk_eq("R3 poll ignored in wait", 32'(proc_state), 32'd3);
  endtask

  task automatic t_frame();
    send_frame(6, 8'hA0, -1);
    chk_eq("R9 writing code 7", 32'(saw_write), 32'd1);
    wait_state(3'd4);
    chk_eq("R4 word0", mem[64], 32'hA3A2_A1A0);
    chk_eq("R4 partial zero fill", mem[65], 32'h0000_A5A4);
    chk_eq("R5 writeback", mem[16], 32'h0006_0300);
    chk_eq("R8 irq set", 32'(irq_rx), 32'd1);
    chk_eq("R7 chained next", 32'(last_desc), 32'h20);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk_eq("R8 irq cleared", 32'(irq_rx), 32'd0);
  endtask

  task automatic t_trunc();
    mem[81] = 32'hFFFF_FFFF;
    mem[82] = 32'hDEAD_BEEF;
    mem[32] = 32'h8000_0000;
    set_desc(36, 1'b0, 64, 1'b1, 1'b1, 96, 48);
    pulse_poll();
    wait_state(3'd3);
    send_frame(9, 8'h10, -1);
    wait_state(3'd4);
    chk_eq("R6 first word", mem[80], 32'h1312_1110);
    chk_eq("R6 cut word", mem[81], 32'h0000_0014);
    chk_eq("R6 beyond buffer untouched", mem[82], 32'hDEAD_BEEF);
    chk_eq("R6 length and error", mem[32], 32'h0005_8300);
    chk_eq("R7 contiguous next", 32'(last_desc), 32'h24);
  endtask

  task automatic t_err_eor();
    mem[36] = 32'h8000_0000;
    pulse_poll();
    wait_state(3'd3);
    send_frame(3, 8'hC0, 1);
    wait_state(3'd4);
    chk_eq("R5 error summary", mem[36], 32'h0003_8300);
    chk_eq("R4 short frame", mem[96], 32'h00C2_C1C0);
    chk_eq("R7 end of ring wins", 32'(last_desc), 32'h10);
  endtask

  task automatic t_stop_restart();
    rx_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_eq("R10 stopped", 32'(proc_state), 32'd0);
    frm_valid = 1'b1;
    @(negedge clk);
    chk_eq("R11 no ready when stopped", 32'(frm_ready), 32'd0);
    frm_valid = 1'b0;
    set_desc(48, 1'b0, 64, 1'b0, 1'b0, 0, 0);
    desc_base = 16'h0030;
    rx_start  = 1'b1;
    wait_state(3'd4);
    chk_eq("R10 restart uses base", 32'(last_desc), 32'h30);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_suspend_and_poll();
    t_frame();
    t_trunc();
    t_err_eor();
    t_stop_restart();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule